// File: doc/BRIEF.md
# Transmit Transceiver Startup Sequencer

This block brings the transmit half of a serial transceiver out of reset in a controlled order. It runs on a free-running system clock. First it holds the PLL and the transmitter in reset. It then releases the PLL and waits for lock, with no reference-clock loss reported. Next it releases the transmitter and waits until the transmit user clock is stable. Only after that does it accept the transceiver's reset-done flag. When the transmit buffer is bypassed, it also runs a phase-alignment handshake. Finally it raises a registered done flag.

Every status input may come from another clock domain, so each one is synchronized before it is used. A settle counter enforces a minimum dwell in every phase before status is trusted. A timeout sends a stalled phase back to the PLL reset for another attempt. A loss of lock after the transmitter has been released also sends the sequence back to the start.

The block has no streaming data path, so all pins are plain level signals with no valid/ready handshake.

Top module: `tx_startup_seq`

## Requirements
- R1: While `soft_rst_i` is high at a clock edge (synchronous, active high), the outputs after that edge are: `pll_rst_o` equal to `OWN_PLL_RST`, `tx_rst_o`=1, `phase_align_o`=0 and `done_o`=0. After release, the sequence restarts from the PLL-reset phase.
- R2: On entry to the PLL-reset phase, `pll_rst_o` stays high for exactly `WAIT_CYCLES` clocks. With `OWN_PLL_RST`=0, `pll_rst_o` is always 0.
- R3: `tx_rst_o` stays high through the PLL-reset phase and the lock-wait phase. It falls only after at least `WAIT_CYCLES` clocks in the lock-wait phase, with synchronized lock high and reference-clock-lost low.
- R4: After the transmit reset is released, the user clock must be seen stable, after at least `WAIT_CYCLES` clocks, before reset-done is accepted. A reset-done that arrives while the user clock is not stable never advances the sequence.
- R5: In any phase after the transmit reset is released, loss of lock or an asserted reference-clock-lost returns the sequencer to the PLL-reset phase.
- R6: With `BUF_BYPASS`=1, `phase_align_o` is high from reset-done acceptance until `phase_aligned_i` is seen, and only then does done rise. With `BUF_BYPASS`=0, `phase_align_o` stays 0 and reset-done leads straight to done.
- R7: A waiting phase that spends `TIMEOUT_CYCLES` clocks without meeting its exit condition returns to the PLL-reset phase.
- R8: `done_o` is high only in the completion phase. It stays high until a soft reset or a lock loss.
- R9: A change on any status input that is sampled at clock edge k affects the outputs first at edge k+`SYNC_STAGES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| soft_rst_i | input | 1 | Synchronous active-high restart of the whole sequence |
| pll_lock_i | input | 1 | PLL lock indication (asynchronous) |
| refclk_lost_i | input | 1 | PLL reference clock lost (asynchronous) |
| usrclk_stable_i | input | 1 | Transmit user clock is stable (asynchronous) |
| tx_rstdone_i | input | 1 | Transceiver transmit reset done (asynchronous) |
| phase_aligned_i | input | 1 | Buffer-bypass phase alignment finished (asynchronous) |
| pll_rst_o | output | 1 | Reset to the shared PLL |
| tx_rst_o | output | 1 | Reset to the transmitter |
| phase_align_o | output | 1 | Request to run buffer-bypass phase alignment |
| done_o | output | 1 | Registered transmit initialization complete |

## Verification
The bench holds lock low so that the lock-wait phase times out. A design with a wrong timeout or settle count would show a low or high run of `pll_rst_o` of the wrong length. The bench also raises reset-done before the user clock is stable. A sequencer that took reset-done without the clock gate would raise done too early. It drops lock and raises reference-clock-lost while in the done phase, and measures the exact latency through the synchronizer. A missing restart, or one stage too many or too few, shows up as done falling in the wrong cycle. Two instances run side by side, one bypassed and one buffered, so a phase-alignment step in the wrong configuration, or a PLL reset driven by the non-owner, is caught.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [2:0] {
    ST_PLL_RST  = 3'd0,
    ST_PLL_WAIT = 3'd1,
    ST_CLK_WAIT = 3'd2,
    ST_RDY_WAIT = 3'd3,
    ST_ALIGN    = 3'd4,
    ST_DONE     = 3'd5
  } seq_st_e;
endpackage

// File: rtl/tx_seq_sync.sv
// Multi-stage level synchronizer for a bundle of independent status bits.
module tx_seq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tx_seq_timer.sv
// Dwell counter: cleared on every phase change, saturates at the timeout.
module tx_seq_timer #(
  parameter int WAIT_CYCLES    = 500,
  parameter int TIMEOUT_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic wait_done,
  output logic tmo_hit
);
  localparam int CW = $clog2(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CYCLES - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)           cnt_q <= '0;
    else if (cnt_q != TMO_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign wait_done = (cnt_q >= WAIT_LAST);
  assign tmo_hit   = (cnt_q == TMO_LAST);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (tmo_hit && !clr) |=> tmo_hit);
endmodule

// File: rtl/tx_seq_ctrl.sv
// Phase controller with registered reset/handshake outputs.
module tx_seq_ctrl
  import tx_seq_pkg::*;
#(
  parameter bit BUF_BYPASS  = 1'b1,
  parameter bit OWN_PLL_RST = 1'b1
) (
  input  logic clk,
  input  logic soft_rst,
  input  logic lock_s,
  input  logic reflost_s,
  input  logic usr_s,
  input  logic rdone_s,
  input  logic aligned_s,
  input  logic wait_done,
  input  logic tmo_hit,
  output logic cnt_clr,
  output logic pll_rst_o,
  output logic tx_rst_o,
  output logic align_o,
  output logic done_o
);
  seq_st_e st_q, st_d;
  logic    lock_ok;

  assign lock_ok = lock_s & ~reflost_s;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PLL_RST:  if (wait_done) st_d = ST_PLL_WAIT;
      ST_PLL_WAIT: begin
        if (wait_done && lock_ok) st_d = ST_CLK_WAIT;
        else if (tmo_hit)         st_d = ST_PLL_RST;
      end
      ST_CLK_WAIT: begin
        if (!lock_ok)                st_d = ST_PLL_RST;
        else if (wait_done && usr_s) st_d = ST_RDY_WAIT;
        else if (tmo_hit)            st_d = ST_PLL_RST;
      end
      ST_RDY_WAIT: begin
        if (!lock_ok)              st_d = ST_PLL_RST;
        else if (usr_s && rdone_s) st_d = BUF_BYPASS ? ST_ALIGN : ST_DONE;
        else if (tmo_hit)          st_d = ST_PLL_RST;
      end
      ST_ALIGN: begin
        if (!lock_ok)       st_d = ST_PLL_RST;
        else if (aligned_s) st_d = ST_DONE;
        else if (tmo_hit)   st_d = ST_PLL_RST;
      end
      ST_DONE:  if (!lock_ok) st_d = ST_PLL_RST;
      default:  st_d = ST_PLL_RST;
    endcase
  end

  assign cnt_clr = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      st_q      <= ST_PLL_RST;
      pll_rst_o <= OWN_PLL_RST;
      tx_rst_o  <= 1'b1;
      align_o   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      pll_rst_o <= OWN_PLL_RST && (st_d == ST_PLL_RST);
      tx_rst_o  <= (st_d == ST_PLL_RST) || (st_d == ST_PLL_WAIT);
      align_o   <= (st_d == ST_ALIGN);
      done_o    <= (st_d == ST_DONE);
    end
  end

  assert_pll_hold_R2: assert property (@(posedge clk) disable iff (soft_rst)
    (st_q == ST_PLL_WAIT && $past(st_q) == ST_PLL_RST) |-> $past(wait_done));
  assert_pll_owner_R2: assert property (@(posedge clk) disable iff (soft_rst)
    (OWN_PLL_RST || !pll_rst_o));
  assert_tx_gate_R3: assert property (@(posedge clk) disable iff (soft_rst)
    $fell(tx_rst_o) |-> $past(lock_ok && wait_done));
  assert_usr_first_R4: assert property (@(posedge clk) disable iff (soft_rst)
    (st_q == ST_RDY_WAIT && $past(st_q) == ST_CLK_WAIT) |-> $past(usr_s && wait_done));
  assert_loss_restart_R5: assert property (@(posedge clk) disable iff (soft_rst)
    (!tx_rst_o && !lock_ok) |=> (st_q == ST_PLL_RST));
  assert_align_path_R6: assert property (@(posedge clk) disable iff (soft_rst)
    $rose(done_o) |-> ($past(align_o) == BUF_BYPASS));
  assert_tmo_retry_R7: assert property (@(posedge clk) disable iff (soft_rst)
    (st_q == ST_PLL_WAIT && tmo_hit && !lock_ok) |=> (st_q == ST_PLL_RST));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (soft_rst)
    (done_o && lock_ok) |=> done_o);
endmodule

// File: rtl/tx_startup_seq.sv
module tx_startup_seq #(
  parameter int WAIT_CYCLES    = 500,
  parameter int TIMEOUT_CYCLES = 65536,
  parameter int SYNC_STAGES    = 2,
  parameter bit BUF_BYPASS     = 1'b1,
  parameter bit OWN_PLL_RST    = 1'b1
) (
  input  logic clk_i,
  input  logic soft_rst_i,
  input  logic pll_lock_i,
  input  logic refclk_lost_i,
  input  logic usrclk_stable_i,
  input  logic tx_rstdone_i,
  input  logic phase_aligned_i,
  output logic pll_rst_o,
  output logic tx_rst_o,
  output logic phase_align_o,
  output logic done_o
);
  localparam int NSTAT = 5;

  logic [NSTAT-1:0] stat_raw, stat_s;
  logic wait_done, tmo_hit, cnt_clr;

  assign stat_raw = {phase_aligned_i, tx_rstdone_i, usrclk_stable_i,
                     refclk_lost_i, pll_lock_i};

  tx_seq_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_i), .rst(soft_rst_i), .d(stat_raw), .q(stat_s));

  tx_seq_timer #(.WAIT_CYCLES(WAIT_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk_i), .rst(soft_rst_i), .clr(cnt_clr),
    .wait_done(wait_done), .tmo_hit(tmo_hit));

  tx_seq_ctrl #(.BUF_BYPASS(BUF_BYPASS), .OWN_PLL_RST(OWN_PLL_RST)) u_ctrl (
    .clk(clk_i), .soft_rst(soft_rst_i),
    .lock_s(stat_s[0]), .reflost_s(stat_s[1]), .usr_s(stat_s[2]),
    .rdone_s(stat_s[3]), .aligned_s(stat_s[4]),
    .wait_done(wait_done), .tmo_hit(tmo_hit), .cnt_clr(cnt_clr),
    .pll_rst_o(pll_rst_o), .tx_rst_o(tx_rst_o),
    .align_o(phase_align_o), .done_o(done_o));
endmodule

// File: tb/tx_startup_seq_tb_top.sv
`timescale 1ns/1ps
module tx_startup_seq_tb_top;
  localparam int WAITC = 8;
  localparam int TMO   = 64;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic soft_rst = 1'b1, lock = 1'b0, lost = 1'b0, usr = 1'b0, rdone = 1'b0, aligned = 1'b0;
  logic a_pll, a_tx, a_al, a_dn, b_pll, b_tx, b_al, b_dn;

  tx_startup_seq #(.WAIT_CYCLES(WAITC), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(SYNC),
                   .BUF_BYPASS(1'b1), .OWN_PLL_RST(1'b1)) dut_i (
    .clk_i(clk), .soft_rst_i(soft_rst), .pll_lock_i(lock), .refclk_lost_i(lost),
    .usrclk_stable_i(usr), .tx_rstdone_i(rdone), .phase_aligned_i(aligned),
    .pll_rst_o(a_pll), .tx_rst_o(a_tx), .phase_align_o(a_al), .done_o(a_dn));

  tx_startup_seq #(.WAIT_CYCLES(WAITC), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(SYNC),
                   .BUF_BYPASS(1'b0), .OWN_PLL_RST(1'b0)) dut_b (
    .clk_i(clk), .soft_rst_i(soft_rst), .pll_lock_i(lock), .refclk_lost_i(lost),
    .usrclk_stable_i(usr), .tx_rstdone_i(rdone), .phase_aligned_i(aligned),
    .pll_rst_o(b_pll), .tx_rst_o(b_tx), .phase_align_o(b_al), .done_o(b_dn));

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 pll-reset,1 lock-wait,2 clock-wait,3 done-wait,4 align,5 done
  int m_ph[2], m_cnt[2];
  logic [4:0] hist [SYNC];

  function automatic int step(int ph, int c, bit ok, bit u, bit d, bit a, bit byp);
    bit settled = (c >= WAITC - 1);
    bit late    = (c == TMO - 1);
    case (ph)
      0: return settled ? 1 : 0;
      1: return (settled && ok) ? 2 : (late ? 0 : 1);
      2: return !ok ? 0 : ((settled && u) ? 3 : (late ? 0 : 2));
      3: return !ok ? 0 : ((u && d) ? (byp ? 4 : 5) : (late ? 0 : 3));
      4: return !ok ? 0 : (a ? 5 : (late ? 0 : 4));
      default: return ok ? 5 : 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (soft_rst) begin
      for (int k = 0; k < 2; k++) begin m_ph[k] = 0; m_cnt[k] = 0; end
      for (int s = 0; s < SYNC; s++) hist[s] = '0;
    end else begin
      logic [4:0] v;
      v = hist[SYNC-1];
      for (int k = 0; k < 2; k++) begin
        int nx;
        nx = step(m_ph[k], m_cnt[k], v[0] && !v[1], v[2], v[3], v[4], k == 0);
        if (nx != m_ph[k]) m_cnt[k] = 0;
        else if (m_cnt[k] < TMO - 1) m_cnt[k]++;
        m_ph[k] = nx;
      end
      for (int s = SYNC - 1; s > 0; s--) hist[s] = hist[s-1];
      hist[0] = {aligned, rdone, usr, lost, lock};
    end
  end

  always @(negedge clk) if (started) begin
    chk("R2 a pll_rst", a_pll, m_ph[0] == 0);
    chk("R3 a tx_rst",  a_tx,  m_ph[0] <= 1);
    chk("R6 a align",   a_al,  m_ph[0] == 4);
    chk("R8 a done",    a_dn,  m_ph[0] == 5);
    chk("R2 b pll_rst", b_pll, 1'b0);
    chk("R3 b tx_rst",  b_tx,  m_ph[1] <= 1);
    chk("R6 b align",   b_al,  m_ph[1] == 4);
    chk("R8 b done",    b_dn,  m_ph[1] == 5);
  end

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    report();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_for(ref logic sig, input logic val, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      if (sig === val) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int n; bit ok;
    cyc(5);
    chk("R1 reset pll_rst", a_pll, 1'b1);
    chk("R1 reset tx_rst", a_tx, 1'b1);
    chk("R1 reset done", a_dn, 1'b0);
    chk("R1 reset non-owner pll_rst", b_pll, 1'b0);
    soft_rst = 1'b0;
    // no lock: lock-wait must time out and retry
    wait_for(a_pll, 1'b0, 50, ok);
    n = 0; while (a_pll === 1'b0 && n < 500) begin n++; cyc(1); end
    chk("R7 timeout length is TIMEOUT", n == TMO, 1'b1);
    n = 0; while (a_pll === 1'b1 && n < 500) begin n++; cyc(1); end
    chk("R2 pll reset held WAIT cycles", n == WAITC, 1'b1);
    // reset-done early, user clock unstable
    lock = 1'b1; rdone = 1'b1;
    ok = 1;
    for (int i = 0; i < 150; i++) begin
      if (a_dn !== 1'b0 || b_dn !== 1'b0 || a_al !== 1'b0) ok = 0;
      cyc(1);
    end
    chk("R4 reset-done ignored without stable user clock", ok, 1'b1);
    usr = 1'b1;
    wait_for(b_dn, 1'b1, 300, ok);
    chk("R6 buffered instance completes without alignment", ok, 1'b1);
    wait_for(a_al, 1'b1, 300, ok);
    chk("R6 bypass instance requests alignment", ok, 1'b1);
    cyc(5);
    chk("R6 done held off during alignment", a_dn, 1'b0);
    aligned = 1'b1;
    wait_for(a_dn, 1'b1, 10, ok);
    chk("R6 done after alignment", ok, 1'b1);
    aligned = 1'b0;
    cyc(50);
    chk("R8 done holds", a_dn & b_dn, 1'b1);
    // reference clock lost: latency through the synchronizer
    lost = 1'b1;
    cyc(SYNC);
    chk("R9 done unchanged before sync latency", a_dn, 1'b1);
    cyc(1);
    chk("R5 refclk lost drops done", a_dn, 1'b0);
    chk("R5 refclk lost restarts PLL reset", a_pll, 1'b1);
    lost = 1'b0; aligned = 1'b1;
    wait_for(a_dn, 1'b1, 300, ok);
    chk("R5 recovery after refclk loss", ok, 1'b1);
    lock = 1'b0;
    cyc(SYNC + 1);
    chk("R5 lock loss drops done", a_dn | b_dn, 1'b0);
    lock = 1'b1;
    wait_for(a_dn, 1'b1, 300, ok);
    chk("R5 recovery after lock loss", ok, 1'b1);
    soft_rst = 1'b1;
    cyc(1);
    chk("R1 soft reset clears done", a_dn, 1'b0);
    chk("R1 soft reset asserts tx_rst", a_tx, 1'b1);
    chk("R1 soft reset asserts pll_rst", a_pll, 1'b1);
    cyc(3);
    soft_rst = 1'b0;
    wait_for(a_dn, 1'b1, 300, ok);
    chk("R1 sequence restarts after soft reset", ok, 1'b1);
    cyc(10);
    report();
  end
endmodule